// File: doc/BRIEF.md
# Approximate-Priority Deflection Permutation Network

This block steers up to four flits from the in-plane input ports of a bufferless deflection router onto its four in-plane output ports, all in the same cycle. Two stages of 2x2 permuter blocks do the work, two blocks per stage. A bufferless router has no place to hold a flit, so every valid flit leaves on some output. A flit that loses a contest is deflected to the other output of that permuter and is never dropped.

The priority between two flits comes from a coarse age class: the top one or two bits of a 5-bit age field. No full magnitude compare is made. When both flits fall in the same class, one bit of a shared 16-bit LFSR picks the winner. Each permuter has its own LFSR bit. A parameter selects the two-bit class mode or the one-bit lite mode. The routing computation that fills in each flit's requested port is outside this block, as are injection, ejection and buffering.

Top module: `aprx_defl_net`

## Requirements
- R1: Every valid input flit appears on exactly one output in the same cycle, and no flit is duplicated. The number of valid outputs always equals the number of valid inputs.
- R2: A single valid flit on any input always leaves on the output it requests, and the other three outputs are invalid. The request is a 2-bit output index.
- R3: Stage one pairs inputs {0,1} and {2,3} and steers each flit by bit 1 of its request. Stage two pairs the flits bound for outputs {0,1} and for outputs {2,3} and steers them by bit 0. When no block receives two valid flits wanting the same side, every flit gets its requested output.
- R4: In the two-bit mode the class is age bits [4:3], where 11 is the oldest and 00 the youngest. When two flits in one permuter want the same side, the flit in the older class takes that side and the other flit takes the other side. A loser in stage one therefore leaves on output {~req[1], req[0]}.
- R5: Age bits below the class bits have no effect on who wins.
- R6: When two contesting flits share a class, the flit on the block's first input wins if the LFSR bit for that block is 1, and the other flit wins if it is 0. The first input is the lower-numbered side. The LFSR bits are: bit 0 for inputs 0/1, bit 1 for inputs 2/3, bit 2 for the stage-two block feeding outputs 0/1, and bit 3 for the block feeding outputs 2/3.
- R7: In the lite mode (CLASS_BITS=1) only age bit 4 sets the class: 1 is old and 0 is young. Ages 11xxx and 10xxx then tie.
- R8: An invalid input never wins a contest, whatever its age or request.
- R9: A flit keeps its request, age and payload unchanged on its way to an output.
- R10: The LFSR is Fibonacci with feedback s[15]^s[13]^s[12]^s[10], shifted in at bit 0. Reset loads the seed 16'hACE1. After reset it advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the LFSR |
| rst | input | 1 | Synchronous active-high reset; loads the LFSR seed |
| in_vld | input | 4 | Valid bit per input port |
| in_dst | input | 8 | Requested output index, 2 bits per input |
| in_age | input | 20 | Age field, 5 bits per input |
| in_data | input | 64 | Payload, 16 bits per input |
| out_vld | output | 4 | Valid bit per output port |
| out_dst | output | 8 | Request field of the flit on each output |
| out_age | output | 20 | Age field of the flit on each output |
| out_data | output | 64 | Payload of the flit on each output |

## Verification
The datapath is purely combinational, so a wrong steering bit, a swapped mux leg or a broken class compare shows up at the outputs in the same cycle it is driven. It appears as a lone flit on the wrong port, a lost or doubled payload, or a young flit beating an old one. The only internal state is the LFSR. A wrong seed, tap set or bit assignment shows up as the wrong winner in same-class contests. The bench runs such contests over successive cycles in each of the four blocks and predicts every outcome from its own model of the sequence, so a bad state is caught within a few cycles of reset.

// File: rtl/aprx_defl_pkg.sv
package aprx_defl_pkg;

    localparam int NPORT     = 4;
    localparam int DIR_W     = 2;
    localparam int AGE_W     = 5;
    localparam int DATA_W    = 16;
    localparam int LFSR_W    = 16;
    localparam int RND_W     = NPORT;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef struct packed {
        logic              vld;
        logic [DIR_W-1:0]  dst;
        logic [AGE_W-1:0]  age;
        logic [DATA_W-1:0] data;
    } flit_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

endpackage

// File: rtl/adn_cls_cmp.sv
module adn_cls_cmp
    import aprx_defl_pkg::*;
#(
    parameter int CLASS_BITS = 2
) (
    input  logic [AGE_W-1:0] age_x,
    input  logic [AGE_W-1:0] age_y,
    output logic             gt,
    output logic             eq
);

    localparam int LOW_W = AGE_W - CLASS_BITS;

    logic unused_low;
    assign unused_low = ^{age_x[LOW_W-1:0], age_y[LOW_W-1:0]};

    generate
        if (CLASS_BITS == 1) begin : g_lite
            assign gt = age_x[AGE_W-1] & ~age_y[AGE_W-1];
            assign eq = ~(age_x[AGE_W-1] ^ age_y[AGE_W-1]);
        end else begin : g_full
            logic [CLASS_BITS-1:0] cx, cy;
            assign cx = age_x[AGE_W-1 -: CLASS_BITS];
            assign cy = age_y[AGE_W-1 -: CLASS_BITS];
            assign gt = (cx > cy);
            assign eq = (cx == cy);
        end
    endgenerate

endmodule

// File: rtl/adn_permuter.sv
module adn_permuter
    import aprx_defl_pkg::*;
#(
    parameter int CLASS_BITS = 2,
    parameter int STEER      = 1
) (
    input  flit_t in_a,
    input  flit_t in_b,
    input  logic  rnd,
    output flit_t out_lo,
    output flit_t out_hi
);

    logic a_gt, ab_eq, a_pri;
    logic side_a, side_b;
    logic a_dir;

    adn_cls_cmp #(.CLASS_BITS(CLASS_BITS)) u_cmp (
        .age_x (in_a.age),
        .age_y (in_b.age),
        .gt    (a_gt),
        .eq    (ab_eq)
    );

    // deterministic when classes differ, pseudorandom when equal
    assign a_pri  = a_gt | (ab_eq & rnd);
    assign side_a = in_a.dst[STEER];
    assign side_b = in_b.dst[STEER];

    always_comb begin
        if (in_a.vld && (!in_b.vld || (side_a != side_b) || a_pri)) begin
            a_dir = side_a;
        end else if (in_b.vld) begin
            a_dir = ~side_b;
        end else begin
            a_dir = 1'b0;
        end
        out_lo = a_dir ? in_b : in_a;
        out_hi = a_dir ? in_a : in_b;
    end

endmodule

// File: rtl/adn_lfsr.sv
module adn_lfsr
    import aprx_defl_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
    parameter int                OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= lfsr_next(state_q);
        end
    end

    assign rnd = state_q[OUT_W-1:0];

endmodule

// File: rtl/aprx_defl_net.sv
module aprx_defl_net
    import aprx_defl_pkg::*;
#(
    parameter int                CLASS_BITS = 2,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT-1:0]          in_vld,
    input  logic [NPORT*DIR_W-1:0]    in_dst,
    input  logic [NPORT*AGE_W-1:0]    in_age,
    input  logic [NPORT*DATA_W-1:0]   in_data,
    output logic [NPORT-1:0]          out_vld,
    output logic [NPORT*DIR_W-1:0]    out_dst,
    output logic [NPORT*AGE_W-1:0]    out_age,
    output logic [NPORT*DATA_W-1:0]   out_data
);

    localparam int HALF = NPORT / 2;

    logic [RND_W-1:0] rnd;
    flit_t            fin     [NPORT];
    flit_t            mid_lo  [HALF];
    flit_t            mid_hi  [HALF];
    flit_t            fout    [NPORT];

    adn_lfsr #(.SEED(LFSR_SEED), .OUT_W(RND_W)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            fin[k].vld  = in_vld[k];
            fin[k].dst  = in_dst[k*DIR_W +: DIR_W];
            fin[k].age  = in_age[k*AGE_W +: AGE_W];
            fin[k].data = in_data[k*DATA_W +: DATA_W];
        end
    end

    // stage one: steer by request bit 1 toward the output half
    generate
        for (genvar g = 0; g < HALF; g++) begin : g_stage1
            adn_permuter #(.CLASS_BITS(CLASS_BITS), .STEER(1)) u_perm (
                .in_a   (fin[2*g]),
                .in_b   (fin[2*g+1]),
                .rnd    (rnd[g]),
                .out_lo (mid_lo[g]),
                .out_hi (mid_hi[g])
            );
        end
    endgenerate

    // stage two: steer by request bit 0 within the half
    adn_permuter #(.CLASS_BITS(CLASS_BITS), .STEER(0)) u_s2_lo (
        .in_a   (mid_lo[0]),
        .in_b   (mid_lo[1]),
        .rnd    (rnd[HALF]),
        .out_lo (fout[0]),
        .out_hi (fout[1])
    );

    adn_permuter #(.CLASS_BITS(CLASS_BITS), .STEER(0)) u_s2_hi (
        .in_a   (mid_hi[0]),
        .in_b   (mid_hi[1]),
        .rnd    (rnd[HALF+1]),
        .out_lo (fout[2]),
        .out_hi (fout[3])
    );

    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            out_vld[k]                   = fout[k].vld;
            out_dst[k*DIR_W +: DIR_W]    = fout[k].dst;
            out_age[k*AGE_W +: AGE_W]    = fout[k].age;
            out_data[k*DATA_W +: DATA_W] = fout[k].data;
        end
    end

endmodule

// File: rtl/aprx_defl_net_chk.sv
module aprx_defl_net_chk
    import aprx_defl_pkg::*;
#(
    parameter int CLASS_BITS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NPORT-1:0]        in_vld,
    input logic [NPORT*DIR_W-1:0]  in_dst,
    input logic [NPORT*AGE_W-1:0]  in_age,
    input logic [NPORT*DATA_W-1:0] in_data,
    input logic [NPORT-1:0]        out_vld,
    input logic [NPORT*DATA_W-1:0] out_data,
    input logic [RND_W-1:0]        rnd
);

    logic [DIR_W-1:0]      d0, d1, lone_d;
    logic [CLASS_BITS-1:0] c0, c1;
    logic [DATA_W-1:0]     w0, w1, at_d0, at_d1, lone_w, at_lone;
    logic                  pair;

    always_comb begin
        d0     = in_dst[DIR_W-1:0];
        d1     = in_dst[2*DIR_W-1 -: DIR_W];
        c0     = in_age[AGE_W-1 -: CLASS_BITS];
        c1     = in_age[2*AGE_W-1 -: CLASS_BITS];
        w0     = in_data[DATA_W-1:0];
        w1     = in_data[2*DATA_W-1 -: DATA_W];
        at_d0  = out_data[d0*DATA_W +: DATA_W];
        at_d1  = out_data[d1*DATA_W +: DATA_W];
        pair   = (in_vld == 4'b0011);
        lone_d = '0;
        lone_w = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (in_vld[k]) begin
                lone_d = in_dst[k*DIR_W +: DIR_W];
                lone_w = in_data[k*DATA_W +: DATA_W];
            end
        end
        at_lone = out_data[lone_d*DATA_W +: DATA_W];
    end

    p_conserve_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(out_vld) == $countones(in_vld));

    p_lone_route_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(in_vld) == 1) |->
            ((out_vld == (NPORT'(1) << lone_d)) && (at_lone == lone_w)));

    p_split_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (pair && (d0[1] != d1[1])) |-> ((at_d0 == w0) && (at_d1 == w1)));

    p_old_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (pair && (d0 == d1) && (c0 > c1)) |-> (at_d0 == w0));

    p_tie_lfsr_r6: assert property (@(posedge clk) disable iff (rst)
        (pair && (d0 == d1) && (c0 == c1)) |-> (at_d0 == (rnd[0] ? w0 : w1)));

endmodule

bind aprx_defl_net aprx_defl_net_chk #(.CLASS_BITS(CLASS_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_dst   (in_dst),
    .in_age   (in_age),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .rnd      (rnd)
);

// File: tb/aprx_defl_net_bench.sv
module aprx_defl_net_bench;

    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0]  in_vld  = '0;
    logic [7:0]  in_dst  = '0;
    logic [19:0] in_age  = '0;
    logic [63:0] in_data = '0;

    logic [3:0]  o_vld, l_vld;
    logic [7:0]  o_dst, l_dst;
    logic [19:0] o_age, l_age;
    logic [63:0] o_data, l_data;

    aprx_defl_net #(.CLASS_BITS(2), .LFSR_SEED(SEED)) u_aprx_defl_net (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_age(in_age),
        .in_data(in_data), .out_vld(o_vld), .out_dst(o_dst), .out_age(o_age),
        .out_data(o_data)
    );

    aprx_defl_net #(.CLASS_BITS(1), .LFSR_SEED(SEED)) u_aprx_defl_net_lite (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_age(in_age),
        .in_data(in_data), .out_vld(l_vld), .out_dst(l_dst), .out_age(l_age),
        .out_data(l_data)
    );

    // independent LFSR model from R10
    logic [15:0] m;
    always @(posedge clk) begin
        if (rst) m <= SEED;
        else     m <= {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};
    end

    typedef struct packed {
        logic            lite;
        logic            exact;
        logic [3:0]      v;
        logic [7:0]      d;
        logic [19:0]     a;
        logic [63:0]     dat;
        logic [3:0][2:0] e;
    } item_t;

    item_t    sbq[$];
    string    tagq[$];
    int       checks = 0;
    int       fails  = 0;
    int       seq    = 0;
    bit       done   = 0;

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [2:0] enc(input int e);
        return (e < 0) ? 3'b000 : {1'b1, e[1:0]};
    endfunction

    // driver: applies a pattern and pushes the expected result
    task automatic put(input bit lite, input logic [3:0] v, input logic [7:0] d,
                       input logic [19:0] a, input int e0, input int e1,
                       input int e2, input int e3, input bit exact, input string tag);
        item_t it;
        seq++;
        it.lite  = lite;
        it.exact = exact;
        it.v     = v;
        it.d     = d;
        it.a     = a;
        for (int k = 0; k < 4; k++) it.dat[16*k +: 16] = {seq[11:0], 4'(k)};
        it.e[0] = enc(e0); it.e[1] = enc(e1); it.e[2] = enc(e2); it.e[3] = enc(e3);
        in_vld  = v;
        in_dst  = d;
        in_age  = a;
        in_data = it.dat;
        sbq.push_back(it);
        tagq.push_back(tag);
    endtask

    task automatic check(input item_t it, input string tag);
        logic [3:0]  ov, ev;
        logic [63:0] od, ed, odm;
        logic [7:0]  odst;
        logic [19:0] oage;
        int          hits;
        bit          ok;
        if (it.lite) begin ov = l_vld; od = l_data; odst = l_dst; oage = l_age; end
        else         begin ov = o_vld; od = o_data; odst = o_dst; oage = o_age; end
        if (it.exact) begin
            ev = '0; ed = '0; odm = '0;
            for (int k = 0; k < 4; k++) begin
                if (it.v[k] && it.e[k][2]) begin
                    ev[it.e[k][1:0]] = 1'b1;
                    ed[16*it.e[k][1:0] +: 16] = it.dat[16*k +: 16];
                end
            end
            for (int j = 0; j < 4; j++) if (ev[j]) odm[16*j +: 16] = od[16*j +: 16];
            checks++;
            if (ov !== ev || odm !== ed) begin
                fails++;
                $display("FAIL %s: vld=%b data=%h expected vld=%b data=%h",
                         tag, ov, odm, ev, ed);
            end
        end
        if (!it.lite) begin
            ok = ($countones(ov) == $countones(it.v));
            for (int k = 0; k < 4; k++) begin
                if (it.v[k]) begin
                    hits = 0;
                    for (int j = 0; j < 4; j++) begin
                        if (ov[j] && od[16*j +: 16] == it.dat[16*k +: 16] &&
                            odst[2*j +: 2] == it.d[2*k +: 2] &&
                            oage[5*j +: 5] == it.a[5*k +: 5]) hits++;
                    end
                    if (hits != 1) ok = 0;
                end
            end
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL R1/R9 %s: out vld=%b data=%h dst=%h age=%h expected each of vld=%b data=%h once",
                         tag, ov, od, odst, oage, it.v, it.dat);
            end
        end
    endtask

    // monitor: pops and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() != 0) check(sbq.pop_front(), tagq.pop_front());
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = 32'h1234_5678;
        // R10 reset: no input, no output during reset
        repeat (3) step();
        put(0, 4'b0000, 8'h00, 20'h0, -1, -1, -1, -1, 1, "R10 idle in reset");
        step();
        rst = 1'b0;
        // R10 first cycle after reset uses seed bit 0; R6 tie in block 0
        put(0, 4'b0011, {2'd0, 2'd0, 2'd0, 2'd0}, {5'd0, 5'd0, 5'b10111, 5'b10000},
            m[0] ? 0 : 2, m[0] ? 2 : 0, -1, -1, 1, "R10 R6 seed tie");
        // R2 lone flit on every input to every output
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < 4; t++) begin
                step();
                put(0, 4'(1 << k), {4{2'(t)}}, {4{5'(k * 7 + t)}},
                    (k == 0) ? t : -1, (k == 1) ? t : -1, (k == 2) ? t : -1,
                    (k == 3) ? t : -1, 1, "R2 lone flit");
            end
        end
        // R8 old invalid flits do not displace a young valid one
        step();
        put(0, 4'b0010, 8'hFF, {5'd31, 5'd31, 5'd0, 5'd31}, -1, 3, -1, -1, 1,
            "R8 invalid never wins");
        // R3 conflict-free patterns
        step();
        put(0, 4'b1111, {2'd1, 2'd3, 2'd2, 2'd0}, {5'd3, 5'd30, 5'd17, 5'd9},
            0, 2, 3, 1, 1, "R3 full permutation");
        step();
        put(0, 4'b0011, {2'd0, 2'd0, 2'd1, 2'd3}, {5'd0, 5'd0, 5'd31, 5'd1},
            3, 1, -1, -1, 1, "R3 split halves");
        // R4 older class wins, loser deflected
        step();
        put(0, 4'b0011, {2'd0, 2'd0, 2'd1, 2'd1}, {5'd0, 5'd0, 5'b10111, 5'b11000},
            1, 3, -1, -1, 1, "R4 stage1 older first");
        step();
        put(0, 4'b0011, {2'd0, 2'd0, 2'd2, 2'd2}, {5'd0, 5'd0, 5'b01000, 5'b00111},
            0, 2, -1, -1, 1, "R4 stage1 older second");
        step();
        put(0, 4'b0101, {2'd0, 2'd0, 2'd0, 2'd0}, {5'd0, 5'b00111, 5'd0, 5'b01000},
            0, -1, 1, -1, 1, "R4 stage2 older");
        step();
        put(0, 4'b0011, {2'd0, 2'd0, 2'd0, 2'd0}, {5'd0, 5'd0, 5'b10000, 5'b11000},
            0, 2, -1, -1, 1, "R4 full mode 11 over 10");
        // R5 R6 ties in every block over successive LFSR states
        for (int i = 0; i < 6; i++) begin
            step();
            put(0, 4'b1100, {2'd3, 2'd3, 2'd0, 2'd0}, {5'b11000, 5'b11111, 5'd0, 5'd0},
                -1, -1, m[1] ? 3 : 1, m[1] ? 1 : 3, 1, "R5 R6 tie block1");
            step();
            put(0, 4'b0101, {2'd0, 2'd0, 2'd0, 2'd0}, {5'd0, 5'b00110, 5'd0, 5'b00001},
                m[2] ? 0 : 1, -1, m[2] ? 1 : 0, -1, 1, "R6 tie block2");
            step();
            put(0, 4'b1010, {2'd3, 2'd0, 2'd3, 2'd0}, {5'b01100, 5'd0, 5'b01011, 5'd0},
                -1, m[3] ? 3 : 2, -1, m[3] ? 2 : 3, 1, "R6 tie block3");
            step();
            put(0, 4'b0011, {2'd0, 2'd0, 2'd1, 2'd1}, {5'd0, 5'd0, 5'b00000, 5'b00111},
                m[0] ? 1 : 3, m[0] ? 3 : 1, -1, -1, 1, "R5 R6 tie block0");
        end
        // R7 lite mode classes
        for (int i = 0; i < 4; i++) begin
            step();
            put(1, 4'b0011, {2'd0, 2'd0, 2'd0, 2'd0}, {5'd0, 5'd0, 5'b10000, 5'b11000},
                m[0] ? 0 : 2, m[0] ? 2 : 0, -1, -1, 1, "R7 lite 11 ties 10");
        end
        step();
        put(1, 4'b0011, {2'd0, 2'd0, 2'd1, 2'd1}, {5'd0, 5'd0, 5'b10000, 5'b01111},
            3, 1, -1, -1, 1, "R7 lite old beats young");
        // R1 random patterns
        for (int i = 0; i < 300; i++) begin
            step();
            r = r * 32'd1664525 + 32'd1013904223;
            put(0, r[31:28], r[27:20], {r[19:0] ^ r[31:12]}, -1, -1, -1, -1, 0,
                "R1 random");
        end
        repeat (4) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule